// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the bus-side front end of a small register file that sits on an I2C-compatible two-wire bus in Standard mode. The system clock oversamples SCL and SDA. Each line passes through a synchronizer. START and STOP are then recovered from the synchronized samples. A shift engine receives and sends bytes and acknowledges them. The engine's only drive onto the bus is an open-drain pull-down enable for SDA. The register file itself stays outside the block and is reached through one read-data input, a single-cycle write strobe with its data word, and the pointer value, which addresses both the read and the write side.

A write transaction carries a pointer byte first. It can then carry one register word, most significant byte first. A read transaction returns the word at the stored pointer, high byte first. The pointer never advances, so every access touches exactly one register. The pointer is also kept from one transaction to the next, so a host can select a register once and then poll it with bare reads. A START or STOP in the middle of a byte drops the transfer at once and releases SDA. An address that does not match leaves the block silent until the next START.

Top module: `regptr_i2c_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, ptr_o is 0 and wr_en_o is 0.
- R2: A START or STOP (SDA falling or rising while SCL is high) seen partway through a byte releases SDA, discards the partial transfer and produces no write pulse.
- R3: The 9th SCL pulse after START is acknowledged (SDA pulled low) only when the upper 7 bits of the first byte equal DEV_ADDR. On any other address the block never pulls SDA low until the next START.
- R4: In a write transaction (first byte bit 0 = 0), the byte after the address is acknowledged and its low PTR_W bits become ptr_o.
- R5: The next NUM_BYTES bytes are acknowledged and are assembled most significant byte first, each byte MSB first. A single one-cycle wr_en_o pulse then presents the word on wr_data_o, and ptr_o does not change.
- R6: Data bytes beyond NUM_BYTES in one write are acknowledged but cause no further write and leave ptr_o unchanged.
- R7: In a read transaction (first byte bit 0 = 1), the block sends the word on rd_data_i at ptr_o, high byte first and MSB first, pulling SDA low only for 0 bits.
- R8: ptr_o is kept across STOP. A transaction made only of START, the read address and data returns the register selected by the earlier pointer byte.
- R9: When the host acknowledges the last byte of a word, the block starts again at the high byte of the same register. The pointer never increments.
- R10: When the host answers a read byte with NAK, the block releases SDA and stays passive until START or STOP.
- R11: Outside START and STOP, sda_oe_o changes only after a falling SCL edge, so it never becomes 1 while SCL is high.
- R12: A write transaction that ends after the pointer byte updates ptr_o and makes no write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ptr_o | output | PTR_W | Stored register pointer, addresses read and write |
| rd_data_i | input | 8*NUM_BYTES | Register-file word at ptr_o |
| wr_en_o | output | 1 | One-cycle write strobe for the register at ptr_o |
| wr_data_o | output | 8*NUM_BYTES | Word to write when wr_en_o is 1 |

## Verification
The bench builds the block with DEV_ADDR 7'h1C, PTR_W 4, NUM_BYTES 2 and SYNC_STAGES 2. The host model uses a quarter-bit of eight system clocks, which leaves several cycles of slack behind the synchronizer delay. A 4-bit pointer gives a 16-entry register model that can be preloaded with distinct words, so a wrong pointer or a stray write shows up in the data read back. Two-byte words are short enough that a single transfer reaches the wrap of the read byte index and the discard of a third written byte.

// File: rtl/regptr_i2c_pkg.sv
package regptr_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_TX,
    ST_MACK,
    ST_TX_LOAD
  } eng_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } eng_phase_e;

endpackage

// File: rtl/regptr_i2c_sync.sv
module regptr_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  // reset to 1: an idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/regptr_i2c_linesync.sv
module regptr_i2c_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [1:0] raw;
  logic [1:0] synced;
  logic       scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    regptr_i2c_sync #(.STAGES(STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (synced[g])
    );
  end

  assign scl_s_o = synced[1];
  assign sda_s_o = synced[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_o;
      sda_q <= sda_s_o;
    end
  end

  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // SCL high on both samples, SDA moved
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;

endmodule

// File: rtl/regptr_i2c_engine.sv
module regptr_i2c_engine
  import regptr_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h1C,
  parameter int         PTR_W     = 4,
  parameter int         NUM_BYTES = 2,
  localparam int        REG_W     = 8 * NUM_BYTES,
  localparam int        IDX_W     = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o
);

  eng_state_e       st_q;
  eng_phase_e       ph_q;
  logic [2:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic             rw_q;
  logic [IDX_W-1:0] idx_q;
  logic [REG_W-1:0] wbuf_q;
  logic [REG_W-1:0] snap_q;
  logic [PTR_W-1:0] ptr_q;
  logic             oe_q;
  logic             wen_q;

  logic [7:0]       rx_byte;
  logic [REG_W-1:0] tx_word;
  logic [7:0]       tx_byte;

  assign rx_byte = {sh_q[6:0], sda_s_i};

  // first byte of a read comes straight from the port, later ones from the snapshot
  always_comb begin
    tx_word = (st_q == ST_ACK_HOLD) ? rd_data_i : snap_q;
    tx_byte = tx_word[8*(NUM_BYTES-1-int'(idx_q)) +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_ADDR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      idx_q     <= '0;
      wbuf_q    <= '0;
      snap_q    <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      wen_q     <= 1'b0;
    end else begin
      wen_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_RX;
        ph_q      <= PH_ADDR;
        bit_cnt_q <= '0;
        idx_q     <= '0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: if (scl_rise_i) begin
            sh_q      <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == 3'd7) begin
              st_q <= ST_ACK_SET;
              case (ph_q)
                PH_ADDR: begin
                  if (rx_byte[7:1] == DEV_ADDR) rw_q <= rx_byte[0];
                  else                          st_q <= ST_IDLE;
                end
                PH_PTR: ptr_q <= rx_byte[PTR_W-1:0];
                default: begin
                  if (int'(idx_q) < NUM_BYTES) begin
                    wbuf_q <= {wbuf_q[REG_W-9:0], rx_byte};
                    idx_q  <= idx_q + 1'b1;
                    if (int'(idx_q) == NUM_BYTES - 1) wen_q <= 1'b1;
                  end
                end
              endcase
            end
          end
          ST_ACK_SET: if (scl_fall_i) begin
            oe_q <= 1'b1;
            st_q <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall_i) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            case (ph_q)
              PH_ADDR: begin
                if (rw_q) begin
                  snap_q <= rd_data_i;
                  sh_q   <= tx_byte;
                  oe_q   <= ~tx_byte[7];
                  st_q   <= ST_TX;
                end else begin
                  ph_q <= PH_PTR;
                  st_q <= ST_RX;
                end
              end
              PH_PTR: begin
                ph_q <= PH_DATA;
                st_q <= ST_RX;
              end
              default: st_q <= ST_RX;
            endcase
          end
          ST_TX: if (scl_fall_i) begin
            if (bit_cnt_q == 3'd7) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else begin
              sh_q      <= {sh_q[6:0], sh_q[7]};
              oe_q      <= ~sh_q[6];
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_MACK: if (scl_rise_i) begin
            if (!sda_s_i) begin
              st_q  <= ST_TX_LOAD;
              idx_q <= (int'(idx_q) == NUM_BYTES - 1) ? '0 : idx_q + 1'b1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          ST_TX_LOAD: if (scl_fall_i) begin
            sh_q      <= tx_byte;
            oe_q      <= ~tx_byte[7];
            bit_cnt_q <= '0;
            st_q      <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_en_o   = wen_q;
  assign wr_data_o = wbuf_q;

endmodule

// File: rtl/regptr_i2c_slave.sv
module regptr_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h1C,
  parameter int         PTR_W       = 4,
  parameter int         NUM_BYTES   = 2,
  parameter int         SYNC_STAGES = 2,
  localparam int        REG_W       = 8 * NUM_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] ptr_o,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  regptr_i2c_linesync #(.STAGES(SYNC_STAGES)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  regptr_i2c_engine #(
    .DEV_ADDR (DEV_ADDR),
    .PTR_W    (PTR_W),
    .NUM_BYTES(NUM_BYTES)
  ) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_s_i   (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .rd_data_i (rd_data_i),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (ptr_o),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o)
  );

endmodule

// File: rtl/regptr_i2c_slave_chk.sv
module regptr_i2c_slave_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             sda_oe_i,
  input logic             wr_en_i,
  input logic [PTR_W-1:0] ptr_i
);

  p_release_on_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !sda_oe_i);

  p_no_write_after_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !wr_en_i);

  p_write_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);

  p_ptr_steady_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> $stable(ptr_i));

  p_drive_moves_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_i) && !$past(start_i || stop_i)) |-> !$past(scl_s_i));

endmodule

bind regptr_i2c_slave regptr_i2c_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_s_i (scl_s),
  .start_i (start_det),
  .stop_i  (stop_det),
  .sda_oe_i(sda_oe_o),
  .wr_en_i (wr_en_o),
  .ptr_i   (ptr_o)
);

// File: tb/regptr_i2c_slave_bench.sv
module regptr_i2c_slave_bench;

  localparam logic [6:0] DEV   = 7'h1C;
  localparam int         PW    = 4;
  localparam int         NB    = 2;
  localparam int         RW    = 8 * NB;
  localparam int         Q     = 8;
  localparam logic [7:0] A_WR  = {DEV, 1'b0};
  localparam logic [7:0] A_RD  = {DEV, 1'b1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_m = 1'b1;
  logic          sda_m = 1'b1;
  logic          sda_line;
  logic          sda_oe_o;
  logic [PW-1:0] ptr_o;
  logic [RW-1:0] rd_data_i;
  logic          wr_en_o;
  logic [RW-1:0] wr_data_o;

  logic [RW-1:0] regs [16];
  int            wr_cnt = 0;
  int            oe_cnt = 0;
  int            bad_edge = 0;
  logic          oe_prev = 1'b0;
  int            n_chk = 0;
  int            n_fail = 0;
  logic          done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe_o;
  assign rd_data_i = regs[ptr_o];

  regptr_i2c_slave #(
    .DEV_ADDR(DEV), .PTR_W(PW), .NUM_BYTES(NB), .SYNC_STAGES(2)
  ) u_regptr_i2c_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe_o),
    .ptr_o    (ptr_o),
    .rd_data_i(rd_data_i),
    .wr_en_o  (wr_en_o),
    .wr_data_o(wr_data_o)
  );

  function automatic logic [RW-1:0] preset(int i);
    return {4'(i), 12'hABC};
  endfunction

  initial for (int i = 0; i < 16; i++) regs[i] <= preset(i);

  always @(posedge clk) begin
    if (wr_en_o) begin
      regs[ptr_o] <= wr_data_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (sda_oe_o) oe_cnt <= oe_cnt + 1;
    if (sda_oe_o && !oe_prev && scl_m) bad_edge <= bad_edge + 1;
    oe_prev <= sda_oe_o;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic bus_bit(input logic b, output logic smp);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    smp = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, ack_n);
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      d = {d[6:0], s};
    end
    bus_bit(~host_ack, s);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", 32'(sda_oe_o), 0);
    chk("R1 ptr", 32'(ptr_o), 0);
    chk("R1 wr_en", 32'(wr_en_o), 0);
  endtask

  task automatic t_write();
    logic a0, a1, a2, a3;
    int w0 = wr_cnt;
    bus_start();
    put_byte(A_WR, a0);
    put_byte(8'h03, a1);
    put_byte(8'hA5, a2);
    put_byte(8'h3C, a3);
    bus_stop();
    chk("R3 addr ack", 32'(a0), 0);
    chk("R4 ptr ack", 32'(a1), 0);
    chk("R5 data ack", 32'({a2, a3}), 0);
    chk("R4 ptr value", 32'(ptr_o), 3);
    chk("R5 word", 32'(regs[3]), 32'h A53C);
    chk("R5 one write", wr_cnt - w0, 1);
  endtask

  task automatic t_read_only(input logic [RW-1:0] exp, input string req);
    logic a0;
    logic [7:0] hi, lo;
    bus_start();
    put_byte(A_RD, a0);
    get_byte(1'b1, hi);
    get_byte(1'b0, lo);
    bus_stop();
    chk({req, " addr ack"}, 32'(a0), 0);
    chk({req, " R7 data"}, 32'({hi, lo}), 32'(exp));
  endtask

  task automatic t_bad_addr();
    logic a0, a1;
    int o0 = oe_cnt;
    bus_start();
    put_byte(8'hAA, a0);
    put_byte(8'h00, a1);
    bus_stop();
    chk("R3 no ack", 32'(a0), 1);
    chk("R3 passive", oe_cnt - o0, 0);
    chk("R3 ptr kept", 32'(ptr_o), 3);
  endtask

  task automatic t_extra();
    logic a0, a1, a2, a3, a4;
    int w0 = wr_cnt;
    bus_start();
    put_byte(A_WR, a0);
    put_byte(8'h07, a1);
    put_byte(8'hA1, a2);
    put_byte(8'hB2, a3);
    put_byte(8'hC3, a4);
    bus_stop();
    chk("R6 extra ack", 32'(a4), 0);
    chk("R6 word", 32'(regs[7]), 32'h A1B2);
    chk("R6 one write", wr_cnt - w0, 1);
    chk("R6 ptr", 32'(ptr_o), 7);
  endtask

  task automatic t_ptr_only();
    logic a0, a1;
    int w0 = wr_cnt;
    bus_start();
    put_byte(A_WR, a0);
    put_byte(8'h02, a1);
    bus_stop();
    chk("R12 no write", wr_cnt - w0, 0);
    chk("R12 ptr", 32'(ptr_o), 2);
    t_read_only(preset(2), "R8 kept ptr");
  endtask

  task automatic t_repeat();
    logic a0;
    logic [7:0] b0, b1, b2, b3;
    bus_start();
    put_byte(A_RD, a0);
    get_byte(1'b1, b0);
    get_byte(1'b1, b1);
    get_byte(1'b1, b2);
    get_byte(1'b0, b3);
    bus_stop();
    chk("R9 wrap", 32'({b0, b1, b2, b3}), {preset(2), preset(2)});
    chk("R9 ptr", 32'(ptr_o), 2);
  endtask

  task automatic t_nak();
    logic a0, a1;
    logic [7:0] b0;
    int o0;
    bus_start();
    put_byte(A_RD, a0);
    get_byte(1'b0, b0);
    o0 = oe_cnt;
    put_byte(8'hFF, a1);
    chk("R10 silent", oe_cnt - o0, 0);
    chk("R10 no ack", 32'(a1), 1);
    bus_stop();
    chk("R10 high byte", 32'(b0), 32'(preset(2) >> 8));
  endtask

  task automatic t_abort();
    logic a, s;
    int w0 = wr_cnt;
    bus_start();
    put_byte(A_WR, a);
    put_byte(8'h09, a);
    put_byte(8'h77, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
    t_read_only(preset(9), "R2 restart");
    chk("R2 no write restart", wr_cnt - w0, 0);
    bus_start();
    put_byte(A_WR, a);
    put_byte(8'h09, a);
    put_byte(8'h55, a);
    for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
    bus_stop();
    chk("R2 no write stop", wr_cnt - w0, 0);
    chk("R2 released", 32'(sda_oe_o), 0);
    chk("R2 reg intact", 32'(regs[9]), 32'(preset(9)));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wait_q();
    t_write();
    t_read_only(16'hA53C, "R8 read only");
    t_bad_addr();
    t_extra();
    t_ptr_only();
    t_repeat();
    t_nak();
    t_abort();
    chk("R11 drive while scl high", bad_edge, 0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule